// File: doc/BRIEF.md
# Switching-Converter Start-up and Fault Sequencer

This block decides, cycle by cycle, whether the pulse-width generator of an offline switching converter may drive its power switch. It takes digital flags from analog comparators (supply above the start level, supply below the stop level, two supply over-voltage levels, feedback above the overload level, feedback below the shutdown level, and two pin-integrity faults). It also takes a one-clock strobe that the pulse-width generator issues once per switching period. From these it produces a single enable bit, the sequencer state and a few status flags.

Switching begins only once the supply has crossed the start level, and it continues until the supply drops below the lower stop level. An over-voltage on the supply, or an overload that has persisted for a set number of switching periods, parks the block in a hold state. Only a full supply collapse and restart leaves that hold state, which gives hiccup-style auto-recovery. Because the overload delay is counted in switching periods, it scales with the programmed frequency. Pulling the feedback below its shutdown level halts switching until it is released. A pin-integrity fault masks the enable for as long as it is present. Every comparator flag passes through a two-flop synchronizer, so a change on a flag reaches the state on the third clock edge.

Top module: `pwr_guard_seq`

## Requirements
- R1: After reset the state is LOCKOUT and `sw_enable` is 0. State encodings on `state_o` are LOCKOUT=0, RUN=1, OVP_HOLD=2, OLP_HOLD=3, REMOTE_OFF=4. LOCKOUT moves to RUN only when `vcc_on_cmp` is 1.
- R2: In RUN, deasserting `vcc_on_cmp` while `vcc_off_cmp` stays 0 keeps RUN (hysteresis). `vcc_off_cmp`=1 sends RUN to LOCKOUT.
- R3: A supply over-voltage in RUN or REMOTE_OFF moves the state to OVP_HOLD with `sw_enable`=0. OVP_HOLD is kept after the over-voltage clears, and also when `vcc_on_cmp` rises. It is left only for LOCKOUT, on `vcc_off_cmp`=1.
- R4: `cfg_ovp_low`=0 selects `vcc_ovp_hi_cmp` as the over-voltage flag and `cfg_ovp_low`=1 selects `vcc_ovp_lo_cmp`. The unselected flag has no effect.
- R5: With `fb_olp_cmp` held at 1 in RUN, the state enters OLP_HOLD on the clock edge of the OLP_CYCLES-th `pwm_cycle_stb` pulse and not before. `olp_timing_o` is 1 while a partial count is held.
- R6: `fb_olp_cmp` returning to 0 before the count expires clears the count, and a later overload starts counting from zero.
- R7: OLP_HOLD persists after the feedback falls and when `vcc_on_cmp` is 1. `vcc_off_cmp`=1 returns it to LOCKOUT.
- R8: `fb_stop_cmp`=1 in RUN gives REMOTE_OFF with `sw_enable`=0. Releasing it returns to RUN with `sw_enable`=1.
- R9: `rt_fault_cmp` or `cs_open_cmp` forces `sw_enable` to 0 and `pin_fault_o` to 1 while held, without changing the state. Switching resumes when the fault clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ovp_low | input | 1 | Static select of the lower over-voltage level |
| vcc_on_cmp | input | 1 | Supply above start level |
| vcc_off_cmp | input | 1 | Supply below stop level |
| vcc_ovp_hi_cmp | input | 1 | Supply above higher over-voltage level |
| vcc_ovp_lo_cmp | input | 1 | Supply above lower over-voltage level |
| fb_olp_cmp | input | 1 | Feedback above overload level |
| fb_stop_cmp | input | 1 | Feedback below shutdown level |
| rt_fault_cmp | input | 1 | Timing-resistor pin shorted or open |
| cs_open_cmp | input | 1 | Current-sense pin open |
| pwm_cycle_stb | input | 1 | One-clock pulse per switching period |
| sw_enable | output | 1 | Switching permitted |
| state_o | output | 3 | Sequencer state |
| pin_fault_o | output | 1 | A pin-integrity fault is present |
| olp_timing_o | output | 1 | Overload count in progress |

## Verification
A vector table steps the supply flags through a full rise, the band between the two levels, and fall. This separates the hysteresis behaviour from a simple level follower. It also passes through remote off, each pin fault alone, and an over-voltage on the unselected level followed by the selected one, which shows whether holds latch or follow their inputs. Directed overload runs stop one strobe short of the limit, drop the feedback and resume, then reach the limit. These runs tell a continuous-duration counter apart from an accumulating one and catch an off-by-one trip point. Further runs try the lower over-voltage select and the restart from each hold state.

// File: rtl/pwr_guard_pkg.sv
// Shared types for the supply-protection sequencer.
// Assumes the state encoding below is observed by software-free test logic only.
package pwr_guard_pkg;
    typedef enum logic [2:0] {
        ST_LOCKOUT  = 3'd0,
        ST_RUN      = 3'd1,
        ST_OVP_HOLD = 3'd2,
        ST_OLP_HOLD = 3'd3,
        ST_REM_OFF  = 3'd4
    } guard_state_t;
endpackage

// File: rtl/pwr_flag_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous comparator flags.
// Assumes each bit is independent; no multi-bit coherence is provided.
module pwr_flag_sync #(
    parameter int WIDTH  = 7,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] pipe [STAGES];

    // first stage captures the raw flags
    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= '0;
        else        pipe[0] <= raw_i;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            // each later stage re-times the previous one
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[g] <= '0;
                else        pipe[g] <= pipe[g-1];
            end
        end
    endgenerate

    assign sync_o = pipe[STAGES-1];
endmodule

// File: rtl/pwr_olp_timer.sv
// Counts switching-period strobes while an overload persists in RUN.
// Assumes the strobe is a single-clock pulse from the same clock domain.
module pwr_olp_timer #(
    parameter int OLP_CYCLES = 3900
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic strobe_i,
    output logic trip_o,
    output logic busy_o
);
    localparam int CW = $clog2(OLP_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(OLP_CYCLES - 1);

    logic [CW-1:0] cnt;

    // advance on each strobe while active, clear when inactive
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i) cnt <= '0;
        else if (strobe_i && cnt != CW'(OLP_CYCLES)) cnt <= cnt + 1'b1;
    end

    assign trip_o = active_i && strobe_i && (cnt == LAST);
    assign busy_o = (cnt != '0);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(OLP_CYCLES));
    assert_clear_on_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (cnt == '0));
endmodule

// File: rtl/pwr_guard_seq.sv
// Start-up and fault sequencer gating the switching enable of a PWM stage.
// Assumes comparator flags are asynchronous and cfg_ovp_low is static.
module pwr_guard_seq
    import pwr_guard_pkg::*;
#(
    parameter int OLP_CYCLES  = 3900,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_ovp_low,
    input  logic       vcc_on_cmp,
    input  logic       vcc_off_cmp,
    input  logic       vcc_ovp_hi_cmp,
    input  logic       vcc_ovp_lo_cmp,
    input  logic       fb_olp_cmp,
    input  logic       fb_stop_cmp,
    input  logic       rt_fault_cmp,
    input  logic       cs_open_cmp,
    input  logic       pwm_cycle_stb,
    output logic       sw_enable,
    output logic [2:0] state_o,
    output logic       pin_fault_o,
    output logic       olp_timing_o
);
    localparam int NFLAG = 7;

    logic [NFLAG-1:0] raw_flags, s_flags;
    logic s_on, s_off, s_ovp, s_olp, s_stop, s_rt, s_cs;
    logic olp_trip, olp_busy;
    guard_state_t state, state_nx;

    assign raw_flags = {vcc_on_cmp, vcc_off_cmp,
                        (cfg_ovp_low ? vcc_ovp_lo_cmp : vcc_ovp_hi_cmp),
                        fb_olp_cmp, fb_stop_cmp, rt_fault_cmp, cs_open_cmp};

    pwr_flag_sync #(.WIDTH(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (raw_flags),
        .sync_o (s_flags)
    );

    assign {s_on, s_off, s_ovp, s_olp, s_stop, s_rt, s_cs} = s_flags;

    pwr_olp_timer #(.OLP_CYCLES(OLP_CYCLES)) u_olp (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (state == ST_RUN && s_olp),
        .strobe_i (pwm_cycle_stb),
        .trip_o   (olp_trip),
        .busy_o   (olp_busy)
    );

    // next-state selection; supply collapse outranks every other event
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOCKOUT:  if (s_on) state_nx = ST_RUN;
            ST_RUN: begin
                if      (s_off)    state_nx = ST_LOCKOUT;
                else if (s_ovp)    state_nx = ST_OVP_HOLD;
                else if (olp_trip) state_nx = ST_OLP_HOLD;
                else if (s_stop)   state_nx = ST_REM_OFF;
            end
            ST_REM_OFF: begin
                if      (s_off)   state_nx = ST_LOCKOUT;
                else if (s_ovp)   state_nx = ST_OVP_HOLD;
                else if (!s_stop) state_nx = ST_RUN;
            end
            ST_OVP_HOLD, ST_OLP_HOLD: if (s_off) state_nx = ST_LOCKOUT;
            default: state_nx = ST_LOCKOUT;
        endcase
    end

    // state register with synchronous reset into lockout
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LOCKOUT;
        else        state <= state_nx;
    end

    assign pin_fault_o  = s_rt || s_cs;
    assign sw_enable    = (state == ST_RUN) && !pin_fault_o;
    assign state_o      = state;
    assign olp_timing_o = olp_busy;

    assert_stay_locked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCKOUT && !s_on) |=> (state == ST_LOCKOUT));
    assert_ovp_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && s_ovp) |=> !sw_enable);
    assert_ovp_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OVP_HOLD) |=> (state == ST_OVP_HOLD || state == ST_LOCKOUT));
    assert_olp_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OLP_HOLD) |=> (state == ST_OLP_HOLD || state == ST_LOCKOUT));
    assert_olp_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_OLP_HOLD) |=> (state != ST_OLP_HOLD || $past(olp_trip)));
endmodule

// File: tb/pwr_guard_seq_test.sv
module pwr_guard_seq_test;
    localparam int NCYC = 20;
    localparam int NVEC = 16;

    logic clk = 0;
    logic rst_n = 0;
    logic cfg_ovp_low = 0;
    logic on = 0, off = 0, o_hi = 0, o_lo = 0, fbh = 0, fbl = 0, rtf = 0, cso = 0, stb = 0;
    logic sw_enable, pin_fault_o, olp_timing_o;
    logic [2:0] state_o;
    int total = 0, bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pwr_guard_seq #(.OLP_CYCLES(NCYC)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_ovp_low(cfg_ovp_low),
        .vcc_on_cmp(on), .vcc_off_cmp(off), .vcc_ovp_hi_cmp(o_hi),
        .vcc_ovp_lo_cmp(o_lo), .fb_olp_cmp(fbh), .fb_stop_cmp(fbl),
        .rt_fault_cmp(rtf), .cs_open_cmp(cso), .pwm_cycle_stb(stb),
        .sw_enable(sw_enable), .state_o(state_o), .pin_fault_o(pin_fault_o),
        .olp_timing_o(olp_timing_o)
    );

    // {on,off,ovp_hi,ovp_lo,fb_olp,fb_stop,rt,cs} , state , enable
    localparam logic [11:0] VEC [NVEC] = '{
        {8'b0000_0000, 3'd0, 1'b0},   // R1 no start below on level
        {8'b1000_0000, 3'd1, 1'b1},   // R1 start
        {8'b0000_0000, 3'd1, 1'b1},   // R2 hysteresis band
        {8'b0000_0100, 3'd4, 1'b0},   // R8 remote off
        {8'b0000_0000, 3'd1, 1'b1},   // R8 release
        {8'b0000_0010, 3'd1, 1'b0},   // R9 timing pin fault
        {8'b0000_0001, 3'd1, 1'b0},   // R9 sense pin open
        {8'b0000_0000, 3'd1, 1'b1},   // R9 fault cleared
        {8'b0001_0000, 3'd1, 1'b1},   // R4 unselected level ignored
        {8'b0010_0000, 3'd2, 1'b0},   // R3 over-voltage
        {8'b0000_0000, 3'd2, 1'b0},   // R3 latched
        {8'b1000_0000, 3'd2, 1'b0},   // R3 on level alone no restart
        {8'b0100_0000, 3'd0, 1'b0},   // R3 collapse to lockout
        {8'b0000_0000, 3'd0, 1'b0},   // R1 stays locked
        {8'b1000_0000, 3'd1, 1'b1},   // R1 restart
        {8'b0100_0000, 3'd0, 1'b0}    // R2 fall below stop level
    };

    task automatic check(input string req, input logic [2:0] est, input logic een);
        total++;
        if (state_o !== est || sw_enable !== een) begin
            bad++;
            $display("FAIL %s: state=%0d en=%0b expected state=%0d en=%0b",
                     req, state_o, sw_enable, est, een);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) stb = 1;
            @(negedge clk) stb = 0;
        end
    endtask

    task automatic restart();
        {on, off, o_hi, o_lo, fbh, fbl, rtf, cso} = 8'b0100_0000;
        settle();
        on = 1; off = 0;
        settle();
        on = 0;
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", 3'd0, 1'b0);
        rst_n = 1;
        settle();
        check("R1 after reset", 3'd0, 1'b0);

        for (int v = 0; v < NVEC; v++) begin
            {on, off, o_hi, o_lo, fbh, fbl, rtf, cso} = VEC[v][11:4];
            settle();
            check($sformatf("vector %0d", v), VEC[v][3:1], VEC[v][0]);
            if (v == 5 || v == 6) check_bit("R9 pin flag", pin_fault_o, 1'b1);
        end

        // R4 lower over-voltage level selected
        cfg_ovp_low = 1;
        restart();
        check("R4 run", 3'd1, 1'b1);
        o_hi = 1; settle();
        check("R4 high flag ignored", 3'd1, 1'b1);
        o_hi = 0; o_lo = 1; settle();
        check("R4 low flag trips", 3'd2, 1'b0);
        cfg_ovp_low = 0;

        // R5 / R6 overload timing
        restart();
        fbh = 1; settle();
        pulses(NCYC - 1);
        settle();
        check("R5 one short of limit", 3'd1, 1'b1);
        check_bit("R5 timing flag", olp_timing_o, 1'b1);
        fbh = 0; settle();
        check_bit("R6 count cleared", olp_timing_o, 1'b0);
        fbh = 1; settle();
        pulses(NCYC - 1);
        settle();
        check("R6 restart from zero", 3'd1, 1'b1);
        pulses(1);
        check("R5 trip at limit", 3'd3, 1'b0);
        fbh = 0; settle();
        check("R7 hold after feedback drop", 3'd3, 1'b0);
        on = 1; settle();
        check("R7 on level alone", 3'd3, 1'b0);
        on = 0; off = 1; settle();
        check("R7 collapse", 3'd0, 1'b0);

        // R3 over-voltage during remote off
        restart();
        fbl = 1; settle();
        check("R8 remote off", 3'd4, 1'b0);
        o_hi = 1; settle();
        check("R3 ovp from remote off", 3'd2, 1'b0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule